// File: doc/BRIEF.md
# Alarm-Match Up-Counter Timer

This block is a memory-mapped 32-bit timer that counts upward from a programmable start value. It advances once per prescaled tick, with the tick rate set by a divider field. When the count reaches a programmable alarm value it raises an interrupt status flag. The flag drives a level interrupt output. Software can either clear the flag by hand (hold mode) or let it drop by itself one cycle after it rises (pulse mode).

Software programs the block over a small register bus. The bus carries a word index, so byte offset = 4 × index. Writing the start-value register overwrites the running count immediately. When reload mode is enabled, writing zero to the start-value register clears the count and parks the counter. It stays parked even though the run bit remains set, until a nonzero start value or any control write releases it.

The request channel uses valid/ready. `bus_ready` is tied high, so every request is taken in the cycle it is presented and no back-pressure is ever applied. Read data returns on `rd_valid`/`rd_data` exactly one cycle after the accepting edge, with no response back-pressure. A requester must therefore take the read data in that cycle.

Top module: `tmr_alarm_counter`

## Requirements
- R1: After reset, the count, start value, alarm, control fields and interrupt status are all zero, `irq` is low and `rd_valid` is low.
- R2: `bus_ready` is always high. A read accepted at a clock edge gives `rd_valid` high for exactly the following cycle, with `rd_data` holding the register value as it was just before that edge.
- R3: Word index 0 holds the start value, 1 the count, 2 control and 4 the alarm. Reads at indices 3, 5, 6 and 7 return the start value. A control read returns hold at bit 0, divider at bits 3:2, reload at bit 6, run at bit 7 and the interrupt status at bit 8, with all other bits zero.
- R4: A write to index 0 sets the count to the written value at the accepting edge and takes priority over a tick in that cycle.
- R5: While running, the count increments by one every 1, 16 or 256 clocks for divider codes 0, 1 and 2; code 3 behaves as 256. A control write restarts the prescaler, so the first tick falls N clocks after the accepting edge.
- R6: The count wraps from 0xFFFFFFFF to 0.
- R7: The interrupt status is set at the tick that makes the count equal the alarm. A start-value write that places the count on the alarm value does not set it.
- R8: With hold (bit 0) set, the status stays set until a write of zero to index 3. A nonzero write there has no effect.
- R9: With hold clear, the status stays high for exactly one cycle per match.
- R10: With reload (bit 6) set, writing zero to index 0 clears the count and stops counting while the run bit still reads 1. With reload clear, a zero write just sets the count to zero and counting continues.
- R11: A stop caused by R10 is released by a nonzero write to index 0 or by any control write.
- R12: `irq` equals the interrupt status. A write to control bit 8 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, constant high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after accept |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level interrupt, equal to status |

## Verification
A stale park latch shows up at a count read as a frozen value while the run bit reads 1. The bench reads the count a few cycles after each release to catch this. A prescaler that fails to restart or wrap shifts the count by one tick. The bench reads the count exactly at multiples of the divider, so that error shows on the first read. An alarm compare against the wrong operand moves `irq` by one cycle, so `irq` is sampled on each cycle around the expected match. A status that fails to hold or drop is visible on `irq` within one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned SLOT_W = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_LOAD  = 3'd0,
    SLOT_COUNT = 3'd1,
    SLOT_CTRL  = 3'd2,
    SLOT_STAT  = 3'd3,
    SLOT_ALARM = 3'd4,
    SLOT_ALT5  = 3'd5,
    SLOT_ALT6  = 3'd6,
    SLOT_ALT7  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    DIV_1   = 2'd0,
    DIV_16  = 2'd1,
    DIV_256 = 2'd2,
    DIV_RSV = 2'd3
  } div_e;

  // control word bit positions (software visible)
  localparam int unsigned CB_HOLD   = 0;
  localparam int unsigned CB_DIV    = 2;
  localparam int unsigned CB_RELOAD = 6;
  localparam int unsigned CB_RUN    = 7;
  localparam int unsigned CB_STAT   = 8;

  typedef struct packed {
    logic run;
    logic reload;
    div_e div;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned STAGE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic restart,
  input  div_e div,
  output logic tick
);
  localparam int unsigned PRE_W = 2 * STAGE_W;

  logic [PRE_W-1:0] pre_q;
  logic             end_short;
  logic             end_long;
  logic             sel;

  assign end_short = &pre_q[STAGE_W-1:0];
  assign end_long  = &pre_q;

  always_comb begin
    unique case (div)
      DIV_1:   sel = 1'b1;
      DIV_16:  sel = end_short;
      default: sel = end_long;
    endcase
  end

  assign tick = enable & sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || !enable) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ctrl_we,
  input  logic             reload,
  input  logic             run,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] cnt,
  output logic             halted,
  output logic             count_en,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             halt_q;

  assign cnt_inc  = cnt_q + 1'b1;
  assign count_en = run & ~halt_q;
  assign hit      = tick & ~ld_we & (cnt_inc == alarm);
  assign cnt      = cnt_q;
  assign halted   = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_we) begin
      cnt_q <= ld_val;
    end else if (tick) begin
      cnt_q <= cnt_inc;
    end
  end

  // park latch: zero start value in reload mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (ld_we) begin
      halt_q <= reload & (ld_val == '0);
    end else if (ctrl_we) begin
      halt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [SLOT_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] cnt,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ld_we,
  output logic              ctrl_we,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] alarm,
  output logic              status
);
  slot_e             slot;
  logic              wr;
  logic              rd;
  logic              st_clr;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] alarm_q;
  ctrl_t             ctrl_q;
  logic              stat_q;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;

  assign slot    = slot_e'(bus_word);
  assign wr      = bus_valid & bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign ld_we   = wr & (slot == SLOT_LOAD);
  assign ctrl_we = wr & (slot == SLOT_CTRL);
  assign st_clr  = wr & (slot == SLOT_STAT) & (bus_wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      alarm_q <= '0;
      ctrl_q  <= '0;
    end else if (wr) begin
      unique case (slot)
        SLOT_LOAD:  load_q  <= bus_wdata;
        SLOT_ALARM: alarm_q <= bus_wdata;
        SLOT_CTRL: begin
          ctrl_q.hold   <= bus_wdata[CB_HOLD];
          ctrl_q.div    <= div_e'(bus_wdata[CB_DIV+1:CB_DIV]);
          ctrl_q.reload <= bus_wdata[CB_RELOAD];
          ctrl_q.run    <= bus_wdata[CB_RUN];
        end
        default: ;
      endcase
    end
  end

  // status: set by a match, cleared by software in hold mode, else self-clearing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (hit) begin
      stat_q <= 1'b1;
    end else if (!ctrl_q.hold || st_clr) begin
      stat_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CB_HOLD]   = ctrl_q.hold;
    ctrl_word[CB_DIV+1:CB_DIV] = ctrl_q.div;
    ctrl_word[CB_RELOAD] = ctrl_q.reload;
    ctrl_word[CB_RUN]    = ctrl_q.run;
    ctrl_word[CB_STAT]   = stat_q;
  end

  always_comb begin
    unique case (slot)
      SLOT_COUNT: rd_mux = cnt;
      SLOT_CTRL:  rd_mux = ctrl_word;
      SLOT_ALARM: rd_mux = alarm_q;
      default:    rd_mux = load_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        rd_data <= rd_mux;
      end
    end
  end

  assign ctrl   = ctrl_q;
  assign alarm  = alarm_q;
  assign status = stat_q;
endmodule

// File: rtl/tmr_alarm_counter.sv
module tmr_alarm_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned STAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [SLOT_W-1:0] bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  logic             ld_we;
  logic             ctrl_we;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] alarm;
  logic [CNT_W-1:0] cnt_q;
  logic             halt_q;
  logic             count_en;
  logic             tick;
  logic             hit_w;
  logic             stat;
  logic             ctrl_hold;

  assign bus_ready = 1'b1;
  assign ctrl_hold = ctrl.hold;
  assign irq       = stat;

  tmr_regs #(.DATA_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .hit       (hit_w),
    .cnt       (cnt_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ld_we     (ld_we),
    .ctrl_we   (ctrl_we),
    .ctrl      (ctrl),
    .alarm     (alarm),
    .status    (stat)
  );

  tmr_prescaler #(.STAGE_W(STAGE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (count_en),
    .restart (ctrl_we),
    .div     (ctrl.div),
    .tick    (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ld_we    (ld_we),
    .ld_val   (bus_wdata),
    .ctrl_we  (ctrl_we),
    .reload   (ctrl.reload),
    .run      (ctrl.run),
    .alarm    (alarm),
    .cnt      (cnt_q),
    .halted   (halt_q),
    .count_en (count_en),
    .hit      (hit_w)
  );
endmodule

// File: rtl/tmr_alarm_counter_chk.sv
module tmr_alarm_counter_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [SLOT_W-1:0] bus_word,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic              rd_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              halted,
  input logic              hold,
  input logic              hit
);
  logic             ld_wr;
  logic             rd_req;
  logic             st_zero;
  logic [CNT_W-1:0] one;

  assign ld_wr   = bus_valid && bus_write && (bus_word == SLOT_LOAD);
  assign rd_req  = bus_valid && !bus_write;
  assign st_zero = bus_valid && bus_write && (bus_word == SLOT_STAT) && (bus_wdata == '0);
  assign one     = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);
  assert_rd_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  assert_load_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> cnt == $past(bus_wdata));
  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_wr) && cnt != $past(cnt)) |-> cnt == $past(cnt) + one);
  assert_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ld_wr) |=> cnt == $past(cnt));
  assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && hold && !st_zero) |=> irq);
  assert_pulse_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !hold && !hit) |=> !irq);
  assert_rise_on_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit));
endmodule

bind tmr_alarm_counter tmr_alarm_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_word  (bus_word),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .irq       (irq),
  .cnt       (cnt_q),
  .halted    (halt_q),
  .hold      (ctrl_hold),
  .hit       (hit_w)
);

// File: tb/tmr_alarm_counter_tb.sv
module tmr_alarm_counter_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] W_LOAD = 3'd0, W_COUNT = 3'd1, W_CTRL = 3'd2,
                         W_STAT = 3'd3, W_ALARM = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_alarm_counter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic bus_wr(input logic [2:0] w, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [2:0] w, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_word = w;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    chk("R2", "rd_valid after accept", {31'b0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "rd_valid", {31'b0, rd_valid}, 0);
    chk("R2", "bus_ready", {31'b0, bus_ready}, 1);
    bus_rd(W_COUNT, v); chk("R1", "count", v, 0);
    @(negedge clk);
    chk("R2", "rd_valid drops", {31'b0, rd_valid}, 0);
    bus_rd(W_CTRL, v);  chk("R1", "ctrl", v, 0);
    bus_rd(W_LOAD, v);  chk("R1", "load", v, 0);
    bus_rd(W_ALARM, v); chk("R1", "alarm", v, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    bus_wr(W_LOAD, 32'h0000_1234);
    bus_rd(W_COUNT, v); chk("R4", "count after load", v, 32'h1234);
    bus_wr(W_ALARM, 32'hA5A5_0001);
    bus_rd(W_ALARM, v); chk("R3", "alarm readback", v, 32'hA5A5_0001);
    bus_rd(W_STAT, v);  chk("R3", "status index reads load", v, 32'h1234);
    for (int i = 5; i < 8; i++) begin
      bus_rd(3'(i), v); chk("R3", "alias reads load", v, 32'h1234);
    end
    bus_wr(W_CTRL, 32'hFFFF_FEFF);
    bus_rd(W_CTRL, v); chk("R3", "ctrl field mask", v, 32'h0000_00CD);
    bus_wr(W_CTRL, 32'h0000_0100);
    bus_rd(W_CTRL, v); chk("R12", "ctrl bit8 write ignored", v, 0);
    chk("R12", "irq after bit8 write", {31'b0, irq}, 0);
  endtask

  task automatic t_rate(input logic [1:0] dv, input int n, input int nd);
    logic [31:0] v;
    bus_wr(W_LOAD, 32'd100);
    bus_wr(W_CTRL, 32'h80 | (32'(dv) << 2));
    repeat (n - 1) @(negedge clk);
    bus_wr(W_CTRL, 32'h0);
    bus_rd(W_COUNT, v);
    chk("R5", "ticks over window", v, 32'(100 + n / nd));
  endtask

  task automatic t_hold;
    logic [31:0] v;
    bus_wr(W_ALARM, 32'd15);
    bus_wr(W_LOAD, 32'd10);
    bus_wr(W_CTRL, 32'h81);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 4) chk("R7", "no irq before match", {31'b0, irq}, 0);
      if (k == 5) chk("R7", "irq at match", {31'b0, irq}, 1);
    end
    chk("R8", "irq held", {31'b0, irq}, 1);
    bus_rd(W_CTRL, v); chk("R12", "status bit in ctrl", v, 32'h181);
    bus_wr(W_STAT, 32'h5);
    chk("R8", "nonzero status write no effect", {31'b0, irq}, 1);
    bus_wr(W_STAT, 32'h0);
    chk("R8", "zero status write clears", {31'b0, irq}, 0);
    repeat (10) @(negedge clk);
    chk("R8", "stays clear", {31'b0, irq}, 0);
    bus_wr(W_CTRL, 32'h0);
  endtask

  task automatic t_pulse;
    bus_wr(W_CTRL, 32'h80);
    bus_wr(W_LOAD, 32'd10);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R9", "one-cycle irq", {31'b0, irq}, (k == 5) ? 32'd1 : 32'd0);
    end
    bus_wr(W_CTRL, 32'h0);
  endtask

  task automatic t_load_on_alarm;
    bus_wr(W_CTRL, 32'h01);
    bus_wr(W_LOAD, 32'd15);
    repeat (3) @(negedge clk);
    chk("R7", "load onto alarm no irq", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    bus_wr(W_ALARM, 32'd1);
    bus_wr(W_LOAD, 32'hFFFF_FFFE);
    bus_wr(W_CTRL, 32'h81);
    @(negedge clk); @(negedge clk);
    chk("R6", "no irq at zero", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6", "irq after wrap match", {31'b0, irq}, 1);
    bus_wr(W_CTRL, 32'h0);
    bus_rd(W_COUNT, v); chk("R6", "count after wrap", v, 32'd2);
    chk("R9", "status drops without hold", {31'b0, irq}, 0);
  endtask

  task automatic t_park;
    logic [31:0] v;
    bus_wr(W_CTRL, 32'hC0);
    bus_wr(W_LOAD, 32'd500);
    bus_wr(W_LOAD, 32'd0);
    repeat (20) @(negedge clk);
    bus_rd(W_COUNT, v); chk("R10", "parked count", v, 0);
    bus_rd(W_CTRL, v);  chk("R10", "run bit still set", v, 32'hC0);
    bus_wr(W_LOAD, 32'd7);
    repeat (9) @(negedge clk);
    bus_rd(W_COUNT, v); chk("R11", "release by nonzero load", v, 32'd16);
    bus_wr(W_LOAD, 32'd0);
    repeat (5) @(negedge clk);
    bus_wr(W_CTRL, 32'hC0);
    repeat (6) @(negedge clk);
    bus_rd(W_COUNT, v); chk("R11", "release by ctrl write", v, 32'd6);
    bus_wr(W_CTRL, 32'h80);
    bus_wr(W_LOAD, 32'd0);
    repeat (9) @(negedge clk);
    bus_rd(W_COUNT, v); chk("R10", "zero load without reload counts", v, 32'd9);
    bus_wr(W_CTRL, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_rate(2'd0, 20, 1);
    t_rate(2'd1, 48, 16);
    t_rate(2'd1, 47, 16);
    t_rate(2'd2, 512, 256);
    t_rate(2'd3, 600, 256);
    t_hold();
    t_pulse();
    t_load_on_alarm();
    t_wrap();
    t_park();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule